// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a fully associative translation cache. Each slot holds a virtual page number, a physical page number, an 8-bit address-space identifier, a global flag (the entry matches under any identifier), a read-enable and a write-enable mask with one bit per privilege mode, a fault-on-read bit, a fault-on-write bit and a valid bit. A lookup presents a virtual page number and the current address-space identifier. One cycle later the block returns hit or miss, the index of the winning slot and its payload. Page-table walking, permission checks and fault reporting belong to the surrounding logic.

Refills go into the slot under a round-robin replacement pointer. A separate index-read port returns the slot under that pointer and can step the pointer when asked. Three single-cycle flush commands clear the entries: all of them, every entry that is not global, or the entries that match one page and identifier pair. A three-slot memory of recently hit indices is searched before the array. Any insert or flush empties it.

Top module: `asn_tlb`

## Requirements
- R1: A slot matches a lookup only when it is valid, its stored page equals `lk_vpn`, and either its global flag is set or its identifier equals `lk_asn`. A matching lookup reports `lk_hit`=1 with that slot's `lk_ppn`, `lk_rd_mask`, `lk_wr_mask`, `lk_global` and fault bits. A lookup with no match reports `lk_hit`=0.
- R2: The lookup result is registered. `lk_done` and `lk_hit` are valid on the first rising edge after `lk_req` and reflect the array as it was in the request cycle. After reset, `lk_done`, `lk_hit` and `rd_done` are 0.
- R3: When several array slots match and none of them is in the recent-hit memory, the lowest index wins.
- R4: Up to three recently hit slot indices are checked first, most recent first. A matching recorded slot wins over the array order. A hit found only through the array is recorded as the most recent, and the oldest record drops out.
- R5: Every insert and every flush empties the recent-hit memory.
- R6: An insert writes `ins_vpn` and its payload into the slot at the replacement pointer, overwriting any occupant, and marks it valid. The pointer then steps by one and wraps from ENTRIES-1 to 0.
- R7: `fl_all` invalidates every slot and returns the replacement pointer to 0.
- R8: `fl_nonglobal` invalidates every slot whose global flag is clear and keeps global slots.
- R9: `fl_one` invalidates every slot whose page equals `fl_vpn` and whose global flag is set or whose identifier equals `fl_asn`. Other slots are kept.
- R10: `idx_req` returns, one cycle later on `rd_*`, the pointer value and the slot it selects. The pointer steps only when `idx_advance` is high in the same cycle.
- R11: A flush command wins over a simultaneous insert. The insert is dropped, and the pointer does not step for it. Among the flush commands, `fl_all` beats `fl_nonglobal`, which beats `fl_one`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a slot |
| lk_index | output | IDX_W | Winning slot index |
| lk_ppn | output | PPN_W | Physical page of the winning slot |
| lk_global | output | 1 | Global flag of the winning slot |
| lk_rd_mask | output | MODE_W | Per-mode read enables |
| lk_wr_mask | output | MODE_W | Per-mode write enables |
| lk_fault_rd | output | 1 | Fault-on-read bit |
| lk_fault_wr | output | 1 | Fault-on-write bit |
| ins_req | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Page number to store as the tag |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_asn | input | ASN_W | Identifier to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_mask | input | MODE_W | Read enables to store |
| ins_wr_mask | input | MODE_W | Write enables to store |
| ins_fault_rd | input | 1 | Fault-on-read to store |
| ins_fault_wr | input | 1 | Fault-on-write to store |
| idx_req | input | 1 | Index-read request |
| idx_advance | input | 1 | Step the pointer with this index read |
| rd_done | output | 1 | Index-read result valid |
| rd_index | output | IDX_W | Pointer value that was read |
| rd_valid | output | 1 | Valid bit of that slot |
| rd_vpn | output | VPN_W | Page tag of that slot |
| rd_ppn | output | PPN_W | Physical page of that slot |
| rd_asn | output | ASN_W | Identifier of that slot |
| rd_global | output | 1 | Global flag of that slot |
| fl_all | input | 1 | Invalidate every slot |
| fl_nonglobal | input | 1 | Invalidate non-global slots |
| fl_one | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for the single-address flush |
| fl_asn | input | ASN_W | Identifier for the single-address flush |

## Verification
Two pairs of functions can fall in the same cycle. The first is a flush and an insert: the bench raises a single-address flush and an insert together. It then judges the result by looking up the inserted page, which must miss, and by an index read, which must show the pointer unmoved. The second is a lookup and a flush: the bench looks up a global page in the same cycle that flushes it. The registered answer must still hit, and a lookup in the next cycle must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Decoded flush command, in priority order.
  typedef enum logic [1:0] {
    FL_NONE      = 2'd0,
    FL_ALL       = 2'd1,
    FL_NONGLOBAL = 2'd2,
    FL_ONE       = 2'd3
  } flush_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASN_W   = 8
) (
  input  logic [ENTRIES-1:0] e_valid,
  input  logic [ENTRIES-1:0] e_glob,
  input  logic [VPN_W-1:0]   e_tag [ENTRIES],
  input  logic [ASN_W-1:0]   e_asn [ENTRIES],
  input  logic [VPN_W-1:0]   q_vpn,
  input  logic [ASN_W-1:0]   q_asn,
  output logic [ENTRIES-1:0] match_vec
);
  // One comparator per slot: tag equal, and global or identifier equal.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = e_valid[e] && (e_tag[e] == q_vpn) &&
                          (e_glob[e] || (e_asn[e] == q_asn));
  end
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)
      ptr <= '0;
    else if (step)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_hit_cache.sv
module tlb_hit_cache #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               lookup,
  input  logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [SLOTS-1:0]   slot_valid
);
  logic [IDX_W-1:0] slot_idx [SLOTS];
  logic [SLOTS-1:0] slot_hit;
  logic             cache_hit;
  logic [IDX_W-1:0] cache_idx;
  logic             array_hit;
  logic [IDX_W-1:0] array_idx;
  logic             promote;

  // A record counts only if the slot it names still matches.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_hit[s] = slot_valid[s] && match_vec[slot_idx[s]];
  end

  // Slot 0 is the most recent, so it is checked first.
  always_comb begin
    cache_hit = 1'b0;
    cache_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        cache_hit = 1'b1;
        cache_idx = slot_idx[s];
      end
    end
  end

  // Priority encoder: the lowest matching index wins.
  always_comb begin
    array_hit = |match_vec;
    array_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) array_idx = IDX_W'(e);
    end
  end

  assign hit     = cache_hit || array_hit;
  assign hit_idx = cache_hit ? cache_idx : array_idx;
  assign promote = lookup && !cache_hit && array_hit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      slot_valid <= '0;
    end else if (promote) begin
      slot_valid  <= {slot_valid[SLOTS-2:0], 1'b1};
      slot_idx[0] <= array_idx;
      for (int s = 1; s < SLOTS; s++) slot_idx[s] <= slot_idx[s-1];
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int ASN_W     = 8,
  parameter int MODE_W    = 4,
  parameter int HIT_SLOTS = 3,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_index,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_global,
  output logic [MODE_W-1:0] lk_rd_mask,
  output logic [MODE_W-1:0] lk_wr_mask,
  output logic              lk_fault_rd,
  output logic              lk_fault_wr,
  input  logic              ins_req,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [MODE_W-1:0] ins_rd_mask,
  input  logic [MODE_W-1:0] ins_wr_mask,
  input  logic              ins_fault_rd,
  input  logic              ins_fault_wr,
  input  logic              idx_req,
  input  logic              idx_advance,
  output logic              rd_done,
  output logic [IDX_W-1:0]  rd_index,
  output logic              rd_valid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [ASN_W-1:0]  rd_asn,
  output logic              rd_global,
  input  logic              fl_all,
  input  logic              fl_nonglobal,
  input  logic              fl_one,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn
);
  // Slot storage: valid and global bits in flops, payload as arrays.
  logic [ENTRIES-1:0] e_valid;
  logic [ENTRIES-1:0] e_glob;
  logic [ENTRIES-1:0] e_frd;
  logic [ENTRIES-1:0] e_fwr;
  logic [VPN_W-1:0]   e_tag [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  logic [MODE_W-1:0]  e_rd  [ENTRIES];
  logic [MODE_W-1:0]  e_wr  [ENTRIES];

  logic [ENTRIES-1:0]   lk_match;
  logic [ENTRIES-1:0]   fl_match;
  logic [IDX_W-1:0]     repl_ptr;
  logic [HIT_SLOTS-1:0] hit_slot_valid;
  logic                 sel_hit;
  logic [IDX_W-1:0]     sel_idx;
  flush_e               fcmd;
  logic                 any_flush;
  logic                 do_insert;
  logic                 ptr_step;

  always_comb begin
    if (fl_all)            fcmd = FL_ALL;
    else if (fl_nonglobal) fcmd = FL_NONGLOBAL;
    else if (fl_one)       fcmd = FL_ONE;
    else                   fcmd = FL_NONE;
  end

  assign any_flush = (fcmd != FL_NONE);
  assign do_insert = ins_req && !any_flush;
  assign ptr_step  = do_insert || (idx_req && idx_advance);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .e_valid  (e_valid),
    .e_glob   (e_glob),
    .e_tag    (e_tag),
    .e_asn    (e_asn),
    .q_vpn    (lk_vpn),
    .q_asn    (lk_asn),
    .match_vec(lk_match)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .e_valid  (e_valid),
    .e_glob   (e_glob),
    .e_tag    (e_tag),
    .e_asn    (e_asn),
    .q_vpn    (fl_vpn),
    .q_asn    (fl_asn),
    .match_vec(fl_match)
  );

  tlb_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clear(fcmd == FL_ALL),
    .step (ptr_step),
    .ptr  (repl_ptr)
  );

  tlb_hit_cache #(.ENTRIES(ENTRIES), .SLOTS(HIT_SLOTS)) u_hit_cache (
    .clk       (clk),
    .rst       (rst),
    .clear     (do_insert || any_flush),
    .lookup    (lk_req),
    .match_vec (lk_match),
    .hit       (sel_hit),
    .hit_idx   (sel_idx),
    .slot_valid(hit_slot_valid)
  );

  // Valid and global bits: flush commands first, then insert.
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst) begin
        e_valid[e] <= 1'b0;
        e_glob[e]  <= 1'b0;
      end else begin
        unique case (fcmd)
          FL_ALL:       e_valid[e] <= 1'b0;
          FL_NONGLOBAL: if (!e_glob[e]) e_valid[e] <= 1'b0;
          FL_ONE:       if (fl_match[e]) e_valid[e] <= 1'b0;
          default: begin
            if (do_insert && (repl_ptr == IDX_W'(e))) begin
              e_valid[e] <= 1'b1;
              e_glob[e]  <= ins_global;
            end
          end
        endcase
      end
    end
  end

  // Payload: single write port at the replacement pointer, no reset.
  always_ff @(posedge clk) begin
    if (do_insert) begin
      e_tag[repl_ptr] <= ins_vpn;
      e_ppn[repl_ptr] <= ins_ppn;
      e_asn[repl_ptr] <= ins_asn;
      e_rd[repl_ptr]  <= ins_rd_mask;
      e_wr[repl_ptr]  <= ins_wr_mask;
      e_frd[repl_ptr] <= ins_fault_rd;
      e_fwr[repl_ptr] <= ins_fault_wr;
    end
  end

  // Registered lookup result.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done     <= 1'b0;
      lk_hit      <= 1'b0;
      lk_index    <= '0;
      lk_ppn      <= '0;
      lk_global   <= 1'b0;
      lk_rd_mask  <= '0;
      lk_wr_mask  <= '0;
      lk_fault_rd <= 1'b0;
      lk_fault_wr <= 1'b0;
    end else begin
      lk_done <= lk_req;
      lk_hit  <= lk_req && sel_hit;
      if (lk_req) begin
        lk_index    <= sel_hit ? sel_idx : '0;
        lk_ppn      <= sel_hit ? e_ppn[sel_idx] : '0;
        lk_global   <= sel_hit && e_glob[sel_idx];
        lk_rd_mask  <= sel_hit ? e_rd[sel_idx] : '0;
        lk_wr_mask  <= sel_hit ? e_wr[sel_idx] : '0;
        lk_fault_rd <= sel_hit && e_frd[sel_idx];
        lk_fault_wr <= sel_hit && e_fwr[sel_idx];
      end
    end
  end

  // Registered index read of the slot at the pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done   <= 1'b0;
      rd_index  <= '0;
      rd_valid  <= 1'b0;
      rd_vpn    <= '0;
      rd_ppn    <= '0;
      rd_asn    <= '0;
      rd_global <= 1'b0;
    end else begin
      rd_done <= idx_req;
      if (idx_req) begin
        rd_index  <= repl_ptr;
        rd_valid  <= e_valid[repl_ptr];
        rd_vpn    <= e_tag[repl_ptr];
        rd_ppn    <= e_ppn[repl_ptr];
        rd_asn    <= e_asn[repl_ptr];
        rd_global <= e_glob[repl_ptr];
      end
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_req,
  input logic               lk_done,
  input logic               lk_hit,
  input logic               ins_req,
  input logic               idx_req,
  input logic               idx_advance,
  input logic               fl_all,
  input logic               fl_nonglobal,
  input logic               fl_one,
  input logic [IDX_W-1:0]   ptr,
  input logic [SLOTS-1:0]   cache_valid,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] glob_vec
);
  logic any_fl;
  assign any_fl = fl_all || fl_nonglobal || fl_one;

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_done);

  assert_hit_needs_done_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);

  assert_ptr_step_on_insert_R6: assert property (@(posedge clk) disable iff (rst)
    (ins_req && !any_fl) |=>
      ptr == IDX_W'(($past(ptr) == IDX_W'(ENTRIES - 1)) ? 0 : int'($past(ptr)) + 1));

  assert_cache_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (ins_req || any_fl) |=> (cache_valid == '0));

  assert_flush_all_empties_R7: assert property (@(posedge clk) disable iff (rst)
    fl_all |=> (valid_vec == '0) && (ptr == '0));

  assert_nonglobal_gone_R8: assert property (@(posedge clk) disable iff (rst)
    (fl_nonglobal && !fl_all) |=> ((valid_vec & ~glob_vec) == '0));

  assert_flush_holds_ptr_R11: assert property (@(posedge clk) disable iff (rst)
    ((fl_nonglobal || fl_one) && !fl_all && !(idx_req && idx_advance)) |=> $stable(ptr));
endmodule

bind asn_tlb tlb_checker #(.ENTRIES(ENTRIES), .SLOTS(HIT_SLOTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_req      (lk_req),
  .lk_done     (lk_done),
  .lk_hit      (lk_hit),
  .ins_req     (ins_req),
  .idx_req     (idx_req),
  .idx_advance (idx_advance),
  .fl_all      (fl_all),
  .fl_nonglobal(fl_nonglobal),
  .fl_one      (fl_one),
  .ptr         (repl_ptr),
  .cache_valid (hit_slot_valid),
  .valid_vec   (e_valid),
  .glob_vec    (e_glob)
);

// File: tb/tb_asn_tlb.sv
module tb_asn_tlb;
  localparam int ENTRIES = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req;
  logic [19:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        lk_done, lk_hit, lk_global, lk_fault_rd, lk_fault_wr;
  logic [1:0]  lk_index;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_rd_mask, lk_wr_mask;
  logic        ins_req, ins_global, ins_fault_rd, ins_fault_wr;
  logic [19:0] ins_vpn, ins_ppn;
  logic [7:0]  ins_asn;
  logic [3:0]  ins_rd_mask, ins_wr_mask;
  logic        idx_req, idx_advance;
  logic        rd_done, rd_valid, rd_global;
  logic [1:0]  rd_index;
  logic [19:0] rd_vpn, rd_ppn;
  logic [7:0]  rd_asn;
  logic        fl_all, fl_nonglobal, fl_one;
  logic [19:0] fl_vpn;
  logic [7:0]  fl_asn;

  int tests = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  asn_tlb #(.ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_index(lk_index), .lk_ppn(lk_ppn),
    .lk_global(lk_global), .lk_rd_mask(lk_rd_mask), .lk_wr_mask(lk_wr_mask),
    .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
    .ins_req(ins_req), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_rd_mask(ins_rd_mask), .ins_wr_mask(ins_wr_mask),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
    .idx_req(idx_req), .idx_advance(idx_advance),
    .rd_done(rd_done), .rd_index(rd_index), .rd_valid(rd_valid), .rd_vpn(rd_vpn),
    .rd_ppn(rd_ppn), .rd_asn(rd_asn), .rd_global(rd_global),
    .fl_all(fl_all), .fl_nonglobal(fl_nonglobal), .fl_one(fl_one),
    .fl_vpn(fl_vpn), .fl_asn(fl_asn)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  asn;
    logic        hit;
    logic [1:0]  idx;
    logic [19:0] ppn;
  } lvec_t;

  // Slots after setup: 0 {100,asn1}, 1 {200,global}, 2 {300,asn2}, 3 {100,global}
  localparam lvec_t LVEC [8] = '{
    '{20'h100, 8'd1, 1'b1, 2'd0, 20'h0A5},  // R3 two match, lowest wins
    '{20'h100, 8'd5, 1'b1, 2'd3, 20'h0D9},  // R1 global only
    '{20'h100, 8'd1, 1'b1, 2'd3, 20'h0D9},  // R4 recorded slot 3 wins
    '{20'h200, 8'd9, 1'b1, 2'd1, 20'h0B6},  // R1 global any identifier
    '{20'h300, 8'd2, 1'b1, 2'd2, 20'h0C7},  // R1 identifier equal
    '{20'h300, 8'd3, 1'b0, 2'd0, 20'h000},  // R1 identifier differs
    '{20'h100, 8'd1, 1'b1, 2'd3, 20'h0D9},  // R4 oldest record still used
    '{20'h400, 8'd1, 1'b0, 2'd0, 20'h000}   // R1 unknown page
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic clear_inputs();
    lk_req = 0; lk_vpn = 0; lk_asn = 0;
    ins_req = 0; ins_vpn = 0; ins_ppn = 0; ins_asn = 0; ins_global = 0;
    ins_rd_mask = 0; ins_wr_mask = 0; ins_fault_rd = 0; ins_fault_wr = 0;
    idx_req = 0; idx_advance = 0;
    fl_all = 0; fl_nonglobal = 0; fl_one = 0; fl_vpn = 0; fl_asn = 0;
  endtask

  task automatic set_insert(input logic [19:0] vpn, input logic [7:0] asn,
                            input logic glob, input logic [19:0] ppn);
    ins_req = 1; ins_vpn = vpn; ins_asn = asn; ins_global = glob; ins_ppn = ppn;
    ins_rd_mask = ppn[3:0]; ins_wr_mask = ppn[7:4];
    ins_fault_rd = ppn[0]; ins_fault_wr = ppn[1];
  endtask

  task automatic insert(input logic [19:0] vpn, input logic [7:0] asn,
                        input logic glob, input logic [19:0] ppn);
    @(negedge clk); set_insert(vpn, asn, glob, ppn);
    @(negedge clk); clear_inputs();
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [7:0] asn);
    @(negedge clk); lk_req = 1; lk_vpn = vpn; lk_asn = asn;
    @(negedge clk); clear_inputs();
  endtask

  task automatic index_read(input logic adv);
    @(negedge clk); idx_req = 1; idx_advance = adv;
    @(negedge clk); clear_inputs();
  endtask

  task automatic flush(input logic a, input logic ng, input logic one,
                       input logic [19:0] vpn, input logic [7:0] asn);
    @(negedge clk); fl_all = a; fl_nonglobal = ng; fl_one = one; fl_vpn = vpn; fl_asn = asn;
    @(negedge clk); clear_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // Reset state
    chk("R2 reset lk_done", lk_done, 0);
    chk("R2 reset lk_hit", lk_hit, 0);
    chk("R2 reset rd_done", rd_done, 0);
    index_read(0);
    chk("R10 reset rd_done", rd_done, 1);
    chk("R10 reset rd_index", rd_index, 0);
    chk("R7 reset slot invalid", rd_valid, 0);

    insert(20'h100, 8'd1, 0, 20'h0A5);
    insert(20'h200, 8'd0, 1, 20'h0B6);
    insert(20'h300, 8'd2, 0, 20'h0C7);
    insert(20'h100, 8'd0, 1, 20'h0D9);

    // Table of lookups
    for (int i = 0; i < 8; i++) begin
      lookup(LVEC[i].vpn, LVEC[i].asn);
      chk($sformatf("R2 done vec%0d", i), lk_done, 1);
      chk($sformatf("R1/R3/R4 hit vec%0d", i), lk_hit, LVEC[i].hit);
      if (LVEC[i].hit) begin
        chk($sformatf("R3/R4 index vec%0d", i), lk_index, LVEC[i].idx);
        chk($sformatf("R1 ppn vec%0d", i), lk_ppn, LVEC[i].ppn);
        chk($sformatf("R1 rd_mask vec%0d", i), lk_rd_mask, LVEC[i].ppn[3:0]);
        chk($sformatf("R1 wr_mask vec%0d", i), lk_wr_mask, LVEC[i].ppn[7:4]);
      end
    end

    // R5: an unrelated flush empties the record, array order returns
    flush(0, 0, 1, 20'h999, 8'd0);
    lookup(20'h100, 8'd1);
    chk("R5 record emptied index", lk_index, 0);
    chk("R5 record emptied ppn", lk_ppn, 20'h0A5);

    // R6/R10: pointer wrapped to 0 after four inserts
    index_read(0);
    chk("R6 wrap rd_index", rd_index, 0);
    chk("R10 rd_vpn", rd_vpn, 20'h100);
    chk("R10 rd_valid", rd_valid, 1);
    chk("R10 rd_global", rd_global, 0);
    index_read(1);
    chk("R10 advancing read index", rd_index, 0);
    index_read(0);
    chk("R10 advanced pointer", rd_index, 1);
    chk("R10 slot 1 global", rd_global, 1);

    // R6: insert overwrites slot 1
    insert(20'h500, 8'd4, 0, 20'h0E3);
    lookup(20'h200, 8'd9);
    chk("R6 overwritten page misses", lk_hit, 0);
    lookup(20'h500, 8'd4);
    chk("R6 new slot hit", lk_hit, 1);
    chk("R6 new slot index", lk_index, 1);
    chk("R6 new slot ppn", lk_ppn, 20'h0E3);
    chk("R1 fault_rd", lk_fault_rd, 1);
    chk("R1 fault_wr", lk_fault_wr, 1);
    insert(20'h600, 8'd4, 0, 20'h0F0);
    insert(20'h700, 8'd4, 0, 20'h070);
    index_read(0);
    chk("R6 pointer wraps to 0", rd_index, 0);

    // R11: flush and insert in the same cycle
    @(negedge clk);
    fl_one = 1; fl_vpn = 20'h600; fl_asn = 8'd4;
    set_insert(20'h800, 8'd4, 0, 20'h080);
    @(negedge clk); clear_inputs();
    lookup(20'h600, 8'd4);
    chk("R9 flushed page misses", lk_hit, 0);
    lookup(20'h800, 8'd4);
    chk("R11 dropped insert misses", lk_hit, 0);
    index_read(0);
    chk("R11 pointer unmoved", rd_index, 0);
    chk("R11 slot 0 intact", rd_vpn, 20'h100);
    lookup(20'h500, 8'd4);
    chk("R9 other page kept", lk_hit, 1);

    // R9: identifier mismatch on a non-global slot keeps it
    flush(0, 0, 1, 20'h500, 8'd7);
    lookup(20'h500, 8'd4);
    chk("R9 identifier mismatch kept", lk_hit, 1);

    // R8: non-global flush keeps global slot
    insert(20'h900, 8'd0, 1, 20'h090);
    flush(0, 1, 0, 20'h0, 8'd0);
    lookup(20'h900, 8'd3);
    chk("R8 global kept", lk_hit, 1);
    chk("R8 global kept index", lk_index, 0);
    chk("R1 global flag out", lk_global, 1);
    lookup(20'h500, 8'd4);
    chk("R8 non-global gone 500", lk_hit, 0);
    lookup(20'h700, 8'd4);
    chk("R8 non-global gone 700", lk_hit, 0);

    // R7: flush-all with pointer away from 0
    insert(20'hA00, 8'd2, 0, 20'h0A1);
    flush(1, 0, 0, 20'h0, 8'd0);
    lookup(20'h900, 8'd3);
    chk("R7 global cleared", lk_hit, 0);
    lookup(20'hA00, 8'd2);
    chk("R7 slot cleared", lk_hit, 0);
    index_read(0);
    chk("R7 pointer reset", rd_index, 0);
    chk("R7 slot invalid", rd_valid, 0);

    // R9 and R2: lookup in the same cycle as a flush of a global slot
    insert(20'hB00, 8'd0, 1, 20'h0B1);
    @(negedge clk);
    lk_req = 1; lk_vpn = 20'hB00; lk_asn = 8'd5;
    fl_one = 1; fl_vpn = 20'hB00; fl_asn = 8'd5;
    @(negedge clk); clear_inputs();
    chk("R2 lookup sees pre-flush state", lk_hit, 1);
    lookup(20'hB00, 8'd5);
    chk("R9 global slot flushed", lk_hit, 0);

    finish_run();
  end
endmodule